// File: doc/BRIEF.md
# Per-Lane DC Balance Encoder and Decoder

This block conditions parallel words before they are serialized onto several independent lanes. On each lane it either forwards the word as it is or sends its bitwise complement. The choice keeps the long-run count of ones and zeros on that lane close to even. A flag bit travels beside each word and records the choice. A small matching decoder sits in the same block. It takes a received word and its flag and returns the original data.

Each lane owns a signed running-imbalance register. That register is seeded from an input while reset is held. It moves only on cycles where input data is valid, and it is clamped to an asymmetric window. A global enable turns balancing off, and the encoder then becomes a registered pass-through. Both the encoder and the decoder have one register stage of latency.

Top module: `dcb_top`

## Requirements
- R1: The imbalance of a word is its count of 1 bits minus its count of 0 bits. When a word is sent complemented, the lane's flag output is 1. When it is sent as-is, the flag is 0.
- R2: If the lane's running imbalance is above zero, a word with positive imbalance is complemented. A word with zero or negative imbalance is sent unchanged.
- R3: If the running imbalance is below zero, a word with positive imbalance is sent unchanged. A word with zero or negative imbalance is complemented.
- R4: If the running imbalance is exactly zero, the word is always complemented.
- R5: After a word is sent unchanged, the running imbalance grows by (word imbalance − 1). After a word is sent complemented, it grows by (1 − word imbalance).
- R6: The running imbalance is held within −6 to +7. Results outside that window are clamped to the nearer limit.
- R7: While `rst` is high, each lane loads its running imbalance from its 4-bit two's-complement field of `seed_rd`. Lane n uses bits [4n+3:4n]. Seeds below −6 load as −6.
- R8: While `bal_en` is 0, valid words leave unchanged, the flag is 0 and the running imbalance does not move.
- R9: On cycles with `in_valid` low, the running imbalance, `out_word` and `out_flag` all hold their values.
- R10: Encoded words appear one clock after the input word. `out_valid` is `in_valid` delayed by one clock.
- R11: Lanes share no state. Lane n takes its word from `in_word[6n+5:6n]` and drives `out_word[6n+5:6n]` and `out_flag[n]`.
- R12: The decoder XORs each received 6-bit word with that lane's received flag. It presents the result one clock later on `dec_word`, with `dec_valid` equal to `rx_valid` delayed by one clock.
- R13: The clock edge on which `rst` is high clears `out_valid`, `out_word`, `out_flag`, `dec_valid` and `dec_word` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the seeds |
| bal_en | input | 1 | 1 enables balancing, 0 gives a pass-through |
| seed_rd | input | 16 | Per-lane signed initial running imbalance, 4 bits per lane |
| in_valid | input | 1 | Input words valid this cycle |
| in_word | input | 24 | Per-lane 6-bit data words |
| out_valid | output | 1 | Encoded words valid |
| out_word | output | 24 | Per-lane encoded words |
| out_flag | output | 4 | Per-lane balance flag (1 = complemented) |
| rx_valid | input | 1 | Received words valid |
| rx_word | input | 24 | Per-lane received words |
| rx_flag | input | 4 | Per-lane received flags |
| dec_valid | output | 1 | Decoded words valid |
| dec_word | output | 24 | Per-lane restored data |

## Verification
Several kinds of input words are used, and each exposes a different class of fault.
- All-zero and all-one words drive the running imbalance to both clamp limits, so they separate a correct window from an off-by-one or symmetric one.
- Balanced words (zero imbalance) split the "zero or negative" branch from the "positive" branch in R2 and R3.
- Random words on lanes seeded with different values show whether lanes leak state into each other.
- Gaps in `in_valid`, and stretches with `bal_en` low, show whether the register moves when it must not.
- The encoder output is looped back into the decoder, so every word must come back unchanged.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  // Clamp an integer into [lo, hi].
  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Complement decision from running imbalance and word imbalance.
  function automatic logic choose_invert(input int run_imb, input int word_imb);
    if (run_imb == 0) return 1'b1;
    if (run_imb > 0)  return (word_imb > 0);
    return (word_imb <= 0);
  endfunction

endpackage

// File: rtl/dcb_lane_enc.sv
module dcb_lane_enc
  import dcb_pkg::*;
#(
  parameter int WORD_W = 6,
  parameter int RD_W   = 4,
  parameter int RD_MAX = 7,
  parameter int RD_MIN = -6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bal_en,
  input  logic [RD_W-1:0]   seed,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic [WORD_W-1:0] out_word,
  output logic              out_flag
);

  logic signed [RD_W-1:0] rd_q;
  int   ones_c;
  int   word_imb;
  int   rd_now;
  int   rd_sum;
  int   rd_nxt;
  int   seed_lim;
  logic inv;

  always_comb begin
    ones_c = 0;
    for (int i = 0; i < WORD_W; i++) ones_c += int'(in_word[i]);
    word_imb = 2 * ones_c - WORD_W;
    rd_now   = int'(rd_q);
    inv      = bal_en && choose_invert(rd_now, word_imb);
    rd_sum   = inv ? (rd_now + 1 - word_imb) : (rd_now + word_imb - 1);
    rd_nxt   = clamp_int(rd_sum, RD_MIN, RD_MAX);
    seed_lim = clamp_int(int'($signed(seed)), RD_MIN, RD_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= RD_W'(seed_lim);
      out_word <= '0;
      out_flag <= 1'b0;
    end else if (in_valid) begin
      out_word <= inv ? ~in_word : in_word;
      out_flag <= inv;
      if (bal_en) rd_q <= RD_W'(rd_nxt);
    end
  end

  // R6: running imbalance stays inside its window
  p_rd_window_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_q) <= RD_MAX) && (int'(rd_q) >= RD_MIN));

  // R9: idle cycles leave all lane state alone
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(rd_q) && $stable(out_word) && $stable(out_flag));

  // R8: disabled balancing forwards data and freezes the register
  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !bal_en) |=> (!out_flag && out_word == $past(in_word) && $stable(rd_q)));

  // R4: zero running imbalance forces complement
  p_zero_inverts_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bal_en && rd_q == '0) |=> (out_flag && out_word == ~$past(in_word)));

endmodule

// File: rtl/dcb_lane_dec.sv
module dcb_lane_dec #(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_flag,
  output logic [WORD_W-1:0] dec_word
);

  always_ff @(posedge clk) begin
    if (rst)           dec_word <= '0;
    else if (rx_valid) dec_word <= rx_word ^ {WORD_W{rx_flag}};
  end

  // R12: a flagged word comes back complemented, an unflagged one untouched
  p_restore_r12: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> ((dec_word ^ $past(rx_word)) == {WORD_W{$past(rx_flag)}}));

endmodule

// File: rtl/dcb_top.sv
module dcb_top #(
  parameter int LANES  = 4,
  parameter int WORD_W = 6,
  parameter int RD_W   = 4,
  parameter int RD_MAX = 7,
  parameter int RD_MIN = -6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bal_en,
  input  logic [LANES*RD_W-1:0]   seed_rd,
  input  logic                    in_valid,
  input  logic [LANES*WORD_W-1:0] in_word,
  output logic                    out_valid,
  output logic [LANES*WORD_W-1:0] out_word,
  output logic [LANES-1:0]        out_flag,
  input  logic                    rx_valid,
  input  logic [LANES*WORD_W-1:0] rx_word,
  input  logic [LANES-1:0]        rx_flag,
  output logic                    dec_valid,
  output logic [LANES*WORD_W-1:0] dec_word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dec_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      dec_valid <= rx_valid;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dcb_lane_enc #(
      .WORD_W(WORD_W), .RD_W(RD_W), .RD_MAX(RD_MAX), .RD_MIN(RD_MIN)
    ) u_enc (
      .clk      (clk),
      .rst      (rst),
      .bal_en   (bal_en),
      .seed     (seed_rd[g*RD_W +: RD_W]),
      .in_valid (in_valid),
      .in_word  (in_word[g*WORD_W +: WORD_W]),
      .out_word (out_word[g*WORD_W +: WORD_W]),
      .out_flag (out_flag[g])
    );

    dcb_lane_dec #(.WORD_W(WORD_W)) u_dec (
      .clk      (clk),
      .rst      (rst),
      .rx_valid (rx_valid),
      .rx_word  (rx_word[g*WORD_W +: WORD_W]),
      .rx_flag  (rx_flag[g]),
      .dec_word (dec_word[g*WORD_W +: WORD_W])
    );
  end

  // R10: encoder valid follows input valid by one clock
  p_out_latency_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_out_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R12: decoder valid follows received valid by one clock
  p_dec_latency_r12: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> dec_valid);

endmodule

// File: tb/sim_dcb_top.sv
module sim_dcb_top;
  localparam int L  = 4;
  localparam int W  = 6;
  localparam int RW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst, bal_en, in_valid, rx_valid;
  logic [L*RW-1:0] seed_rd;
  logic [L*W-1:0]  in_word, rx_word;
  logic [L-1:0]    rx_flag;
  logic            out_valid, dec_valid;
  logic [L*W-1:0]  out_word, dec_word;
  logic [L-1:0]    out_flag;

  dcb_top u0 (
    .clk(clk), .rst(rst), .bal_en(bal_en), .seed_rd(seed_rd),
    .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word), .out_flag(out_flag),
    .rx_valid(rx_valid), .rx_word(rx_word), .rx_flag(rx_flag),
    .dec_valid(dec_valid), .dec_word(dec_word)
  );

  int checks = 0;
  int failures = 0;
  string cur_req = "R13";

  // reference model state
  int         rd[L];
  logic [W-1:0] e_word[L];
  logic       e_flag[L];
  logic       e_valid;
  string      e_tag[L];
  logic [W-1:0] src_hold[L];
  logic [W-1:0] rx_src[L];
  logic       e_dvalid;
  logic [W-1:0] e_dec[L];

  function automatic int clampi(input int v);
    if (v > 7)  return 7;
    if (v < -6) return -6;
    return v;
  endfunction

  function automatic int imb(input logic [W-1:0] w);
    int n = 0;
    for (int i = 0; i < W; i++) if (w[i]) n++;
    return 2 * n - W;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      for (int l = 0; l < L; l++) begin
        rd[l] = clampi(int'($signed(seed_rd[l*RW +: RW])));
        e_word[l] = '0; e_flag[l] = 1'b0; src_hold[l] = '0; e_dec[l] = '0;
        e_tag[l] = "R13";
      end
      e_valid = 1'b0; e_dvalid = 1'b0;
    end else begin
      e_valid = in_valid;
      e_dvalid = rx_valid;
      for (int l = 0; l < L; l++) begin
        logic [W-1:0] w;
        int d;
        logic inv;
        if (rx_valid) e_dec[l] = rx_src[l];
        w = in_word[l*W +: W];
        d = imb(w);
        if (!in_valid) begin
          e_tag[l] = "R9";
        end else if (!bal_en) begin
          e_word[l] = w; e_flag[l] = 1'b0; e_tag[l] = "R8"; src_hold[l] = w;
        end else begin
          if (rd[l] == 0)     begin inv = 1'b1;     e_tag[l] = "R4"; end
          else if (rd[l] > 0) begin inv = (d > 0);  e_tag[l] = "R2"; end
          else                begin inv = (d <= 0); e_tag[l] = "R3"; end
          rd[l] = clampi(inv ? rd[l] + 1 - d : rd[l] + d - 1);
          e_word[l] = inv ? ~w : w;
          e_flag[l] = inv;
          src_hold[l] = w;
        end
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    chk(rst ? "R13" : "R10", "out_valid", int'(out_valid), int'(e_valid));
    chk(rst ? "R13" : "R12", "dec_valid", int'(dec_valid), int'(e_dvalid));
    for (int l = 0; l < L; l++) begin
      string t;
      t = {e_tag[l], "/", cur_req};
      chk(t, $sformatf("lane%0d out_word", l), int'(out_word[l*W +: W]), int'(e_word[l]));
      chk(t, $sformatf("lane%0d out_flag(R1)", l), int'(out_flag[l]), int'(e_flag[l]));
      chk(rst ? "R13" : "R12", $sformatf("lane%0d dec_word", l), int'(dec_word[l*W +: W]), int'(e_dec[l]));
    end
    // loop the encoder output back into the decoder
    rx_valid = out_valid;
    rx_word  = out_word;
    rx_flag  = out_flag;
    for (int l = 0; l < L; l++) rx_src[l] = src_hold[l];
  endtask

  task automatic set_seeds(input int s0, input int s1, input int s2, input int s3);
    seed_rd = {RW'(s3), RW'(s2), RW'(s1), RW'(s0)};
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic all_lanes(input logic [W-1:0] w);
    in_word = {L{w}};
  endtask

  task automatic rand_words();
    for (int l = 0; l < L; l++) in_word[l*W +: W] = W'($urandom);
  endtask

  initial begin
    rst = 1'b1; bal_en = 1'b1; in_valid = 1'b0; in_word = '0;
    rx_valid = 1'b0; rx_word = '0; rx_flag = '0;
    for (int l = 0; l < L; l++) rx_src[l] = '0;
    set_seeds(0, 3, -4, 7);

    cur_req = "R13";
    do_reset();

    cur_req = "R11";
    in_valid = 1'b1;
    for (int i = 0; i < 12; i++) begin rand_words(); step(); end

    cur_req = "R1";
    all_lanes(6'b000000); step(); step();
    all_lanes(6'b111111); step(); step();
    all_lanes(6'b000111); step(); step(); step();
    all_lanes(6'b101010); step(); step();
    all_lanes(6'b011111); step(); step();

    cur_req = "R9";
    for (int i = 0; i < 16; i++) begin
      in_valid = (i % 3 != 1);
      rand_words(); step();
    end

    cur_req = "R8";
    in_valid = 1'b1; bal_en = 1'b0;
    for (int i = 0; i < 8; i++) begin rand_words(); step(); end
    bal_en = 1'b1;
    for (int i = 0; i < 4; i++) begin rand_words(); step(); end

    cur_req = "R6";
    set_seeds(0, 1, 7, -6);
    do_reset();
    in_valid = 1'b1;
    in_word = {6'b000000, 6'b111111, 6'b000000, 6'b000000};
    step();
    all_lanes(6'b000111); step(); step(); step();
    for (int i = 0; i < 6; i++) begin rand_words(); step(); end

    cur_req = "R7";
    set_seeds(-8, -7, -6, 8);
    do_reset();
    in_valid = 1'b1;
    all_lanes(6'b000111); step(); step(); step();
    all_lanes(6'b110111); step(); step();

    cur_req = "R5";
    set_seeds(2, -1, 5, -3);
    do_reset();
    for (int i = 0; i < 400; i++) begin
      in_valid = ($urandom % 5) != 0;
      bal_en   = ($urandom % 10) != 0;
      rand_words(); step();
    end
    in_valid = 1'b0; step(); step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule